// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a direct memory access engine. It moves a programmed number of data items between a peripheral-side address and a memory-side address without processor involvement. Each item is a single read from the current source address followed by a single write to the current destination address. The transfer direction selects which side is the source.

Each side has its own data width (byte, halfword or word) and its own address-increment enable. A fixed peripheral data register is therefore a normal case. Width mismatches are resolved as follows:
- A narrow source is zero-extended into a wide destination.
- A wide source is truncated to the low bits of a narrow destination.

In peripheral mode each item is started by a four-phase request/acknowledge handshake. In memory-to-memory mode items run back to back. The channel has three sticky event flags (half done, all done, error) and one interrupt line, and an optional circular mode that restarts the transfer automatically. The configuration is captured when the channel starts. It may be changed freely while the channel is idle.

Top module: `dma_xfer_channel`

## Requirements
- R1: When `cfg_en` rises and `cfg_count` is nonzero, the channel captures its configuration, loads `remaining` with `cfg_count`, and raises `chan_active` on the next cycle. `remaining` drops by exactly one per completed item. After a stop, a new start needs a fresh low-to-high transition of `cfg_en`.
- R2: Each item is one bus read (`bus_write`=0) at the source address, then one bus write (`bus_write`=1) at the destination address. The write data comes from that read. The count decrements only when the write completes. A bus beat completes on a cycle with `bus_valid` and `bus_ready` high. The first item uses the two base addresses.
- R3: After each item, a side whose increment enable is set advances by its width in bytes (1, 2 or 4). A side whose increment enable is clear keeps the same address.
- R4: Width codes are 0 = byte, 1 = halfword and 2 = word. The written data is the read data masked to the narrower of the two widths: zero-filled above a narrow source, and only the low bits kept from a wide source. Read data arrives right-justified on `bus_rdata`.
- R5: When the current source address (during the read) or destination address (during the write) is not a multiple of that side's width, the channel does not drive `bus_valid`. It sets `flag_err`, drops `chan_active`, and leaves `remaining` unchanged.
- R6: `flag_half` sets on the item that brings `remaining` to floor(N/2). `flag_done` sets on the item that brings it to 0. All flags are sticky. `flag_clr` clears them, one bit per flag (bit 0 half, bit 1 done, bit 2 error); a flag event in the same cycle wins over its clear bit.
- R7: `irq` is high exactly when some flag is set whose matching enable (`cfg_ie_half`, `cfg_ie_done`, `cfg_ie_err`) is high.
- R8: In peripheral mode, no bus access happens until `per_req` is seen. `per_ack` rises on the cycle after the request is accepted and holds while `per_req` stays high. It falls the cycle after `per_req` falls. A new request is accepted only once `per_ack` is low.
- R9: With `cfg_m2m` set, items run back to back with no request and no acknowledge.
- R10: With `cfg_circ` set and `cfg_m2m` clear, completion sets `flag_done`, reloads the count and both addresses, and keeps the channel active. In memory-to-memory mode, circular mode is ignored and the channel stops at zero.
- R11: Dropping `cfg_en` while active stops the channel on the next cycle. `remaining` keeps its value, and later requests get no acknowledge.
- R12: A completed beat with `bus_err` high sets `flag_err` and stops the channel. If the failing beat is a write, it does not decrement the count.
- R13: After reset all outputs are low and `remaining` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Channel enable; a rising edge starts, low aborts |
| cfg_dir | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| cfg_m2m | input | 1 | Memory-to-memory mode (no handshake) |
| cfg_circ | input | 1 | Circular reload on completion |
| cfg_per_inc | input | 1 | Peripheral address increment enable |
| cfg_mem_inc | input | 1 | Memory address increment enable |
| cfg_per_size | input | 2 | Peripheral width code |
| cfg_mem_size | input | 2 | Memory width code |
| cfg_per_base | input | ADDR_W | Peripheral base address |
| cfg_mem_base | input | ADDR_W | Memory base address |
| cfg_count | input | CNT_W | Number of items |
| cfg_ie_half | input | 1 | Interrupt enable for half flag |
| cfg_ie_done | input | 1 | Interrupt enable for done flag |
| cfg_ie_err | input | 1 | Interrupt enable for error flag |
| flag_clr | input | 3 | Write-one-to-clear for flags (half, done, error) |
| per_req | input | 1 | Peripheral request |
| per_ack | output | 1 | Acknowledge to peripheral |
| bus_valid | output | 1 | Bus beat valid |
| bus_write | output | 1 | 1 for write beat, 0 for read beat |
| bus_addr | output | ADDR_W | Beat byte address |
| bus_size | output | 2 | Beat width code |
| bus_wdata | output | 32 | Write data, right-justified |
| bus_ready | input | 1 | Beat completes this cycle |
| bus_rdata | input | 32 | Read data, right-justified |
| bus_err | input | 1 | Completed beat failed |
| flag_half | output | 1 | Half-transfer flag |
| flag_done | output | 1 | Transfer-complete flag |
| flag_err | output | 1 | Transfer-error flag |
| irq | output | 1 | OR of enabled flags |
| remaining | output | CNT_W | Items left |
| chan_active | output | 1 | Channel running |

## Verification
The assertions rely on three properties of the inputs:
- `bus_err` only matters together with `bus_ready`.
- The peripheral keeps `per_req` high until it sees `per_ack`.
- Configuration inputs change only while `chan_active` is low.

The bench drives the bus as a memory model whose read data is a fixed function of the address, with a repeating stall pattern on `bus_ready`. The only error pulse it raises is on an address it has marked. It changes configuration only after `cfg_en` is low, and its peripheral task drops the request only after the acknowledge arrives.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_REQ = 2'd1,
        ST_READ     = 2'd2,
        ST_WRITE    = 2'd3
    } chan_st_e;

    // Bytes moved by one beat of the given width code.
    function automatic logic [2:0] width_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Low address bits that must be zero for the given width code.
    function automatic logic [1:0] align_bits(input logic [1:0] sz);
        case (sz)
            2'd0:    return 2'b00;
            2'd1:    return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return DATA_W'(32'h0000_00FF);
            2'd1:    return DATA_W'(32'h0000_FFFF);
            default: return {DATA_W{1'b1}};
        endcase
    endfunction
endpackage

// File: rtl/dma_side_addr.sv
module dma_side_addr
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [1:0]        size,
    input  logic              inc_en,
    output logic              aligned,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] step;

    always_comb begin
        step      = inc_en ? ADDR_W'(width_bytes(size)) : '0;
        next_addr = cur_addr + step;
        aligned   = (cur_addr[1:0] & align_bits(size)) == 2'b00;
    end
endmodule

// File: rtl/dma_width_fit.sv
module dma_width_fit
    import dma_xfer_pkg::*;
(
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        src_size,
    input  logic [1:0]        dst_size,
    output logic [DATA_W-1:0] fitted
);
    // Masking by both widths zero-fills a narrow source and truncates a wide one.
    always_comb begin
        fitted = rdata & width_mask(src_size) & width_mask(dst_size);
    end
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_dir,
    input  logic              cfg_m2m,
    input  logic              cfg_circ,
    input  logic              cfg_per_inc,
    input  logic              cfg_mem_inc,
    input  logic [1:0]        cfg_per_size,
    input  logic [1:0]        cfg_mem_size,
    input  logic [ADDR_W-1:0] cfg_per_base,
    input  logic [ADDR_W-1:0] cfg_mem_base,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [2:0]        flag_clr,
    input  logic              per_req,
    input  logic              bus_ready,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] fit_data,
    input  logic              per_aligned,
    input  logic              mem_aligned,
    input  logic [ADDR_W-1:0] per_next,
    input  logic [ADDR_W-1:0] mem_next,
    output logic [ADDR_W-1:0] per_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        per_size,
    output logic [1:0]        mem_size,
    output logic              per_inc,
    output logic              mem_inc,
    output logic [1:0]        src_size,
    output logic [1:0]        dst_size,
    output logic              per_ack,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              flag_half,
    output logic              flag_done,
    output logic              flag_err,
    output logic [CNT_W-1:0]  remaining,
    output logic              chan_active
);
    typedef struct packed {
        chan_st_e          st;
        logic              en_prev;
        logic              ack;
        logic [ADDR_W-1:0] paddr;
        logic [ADDR_W-1:0] maddr;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
        logic              dir;
        logic              m2m;
        logic              circ;
        logic              pinc;
        logic              minc;
        logic [1:0]        psize;
        logic [1:0]        msize;
        logic [ADDR_W-1:0] pbase;
        logic [ADDR_W-1:0] mbase;
        logic [CNT_W-1:0]  total;
        logic              half;
        logic              done;
        logic              err;
    } chan_state_t;

    chan_state_t state_d, state_q;

    logic             src_ok_d, dst_ok_d;
    logic [CNT_W-1:0] cnt_dec_d;
    chan_st_e         item_st_d;

    // Source and destination views of the two sides.
    always_comb begin
        src_ok_d = state_q.dir ? mem_aligned : per_aligned;
        dst_ok_d = state_q.dir ? per_aligned : mem_aligned;
    end

    always_comb begin
        state_d         = state_q;
        state_d.en_prev = cfg_en;
        cnt_dec_d       = state_q.cnt - CNT_W'(1);
        item_st_d       = state_q.m2m ? ST_READ : ST_WAIT_REQ;

        // Four-phase handshake: release acknowledge once the request is gone.
        if (state_q.ack && !per_req) begin
            state_d.ack = 1'b0;
        end

        if (flag_clr[0]) state_d.half = 1'b0;
        if (flag_clr[1]) state_d.done = 1'b0;
        if (flag_clr[2]) state_d.err  = 1'b0;

        case (state_q.st)
            ST_IDLE: begin
                if (cfg_en && !state_q.en_prev && (cfg_count != '0)) begin
                    state_d.dir   = cfg_dir;
                    state_d.m2m   = cfg_m2m;
                    state_d.circ  = cfg_circ;
                    state_d.pinc  = cfg_per_inc;
                    state_d.minc  = cfg_mem_inc;
                    state_d.psize = cfg_per_size;
                    state_d.msize = cfg_mem_size;
                    state_d.pbase = cfg_per_base;
                    state_d.mbase = cfg_mem_base;
                    state_d.paddr = cfg_per_base;
                    state_d.maddr = cfg_mem_base;
                    state_d.total = cfg_count;
                    state_d.cnt   = cfg_count;
                    state_d.st    = cfg_m2m ? ST_READ : ST_WAIT_REQ;
                end
            end
            ST_WAIT_REQ: begin
                if (per_req && !state_q.ack) begin
                    state_d.ack = 1'b1;
                    state_d.st  = ST_READ;
                end
            end
            ST_READ: begin
                if (!src_ok_d) begin
                    state_d.err = 1'b1;
                    state_d.st  = ST_IDLE;
                end else if (bus_ready) begin
                    if (bus_err) begin
                        state_d.err = 1'b1;
                        state_d.st  = ST_IDLE;
                    end else begin
                        state_d.data = fit_data;
                        state_d.st   = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (!dst_ok_d) begin
                    state_d.err = 1'b1;
                    state_d.st  = ST_IDLE;
                end else if (bus_ready) begin
                    if (bus_err) begin
                        state_d.err = 1'b1;
                        state_d.st  = ST_IDLE;
                    end else begin
                        state_d.paddr = per_next;
                        state_d.maddr = mem_next;
                        state_d.cnt   = cnt_dec_d;
                        if (cnt_dec_d == (state_q.total >> 1)) begin
                            state_d.half = 1'b1;
                        end
                        if (cnt_dec_d == '0) begin
                            state_d.done = 1'b1;
                            if (state_q.circ && !state_q.m2m) begin
                                state_d.cnt   = state_q.total;
                                state_d.paddr = state_q.pbase;
                                state_d.maddr = state_q.mbase;
                                state_d.st    = item_st_d;
                            end else begin
                                state_d.st = ST_IDLE;
                            end
                        end else begin
                            state_d.st = item_st_d;
                        end
                    end
                end
            end
            default: state_d.st = ST_IDLE;
        endcase

        // Abort: dropping the enable stops the channel wherever it is.
        if ((state_q.st != ST_IDLE) && !cfg_en) begin
            state_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign per_addr    = state_q.paddr;
    assign mem_addr    = state_q.maddr;
    assign per_size    = state_q.psize;
    assign mem_size    = state_q.msize;
    assign per_inc     = state_q.pinc;
    assign mem_inc     = state_q.minc;
    assign src_size    = state_q.dir ? state_q.msize : state_q.psize;
    assign dst_size    = state_q.dir ? state_q.psize : state_q.msize;
    assign per_ack     = state_q.ack;
    assign bus_valid   = ((state_q.st == ST_READ) && src_ok_d) ||
                         ((state_q.st == ST_WRITE) && dst_ok_d);
    assign bus_write   = (state_q.st == ST_WRITE);
    assign bus_addr    = ((state_q.st == ST_READ) ^ state_q.dir) ? state_q.paddr : state_q.maddr;
    assign bus_size    = (state_q.st == ST_READ) ? src_size : dst_size;
    assign bus_wdata   = state_q.data;
    assign flag_half   = state_q.half;
    assign flag_done   = state_q.done;
    assign flag_err    = state_q.err;
    assign remaining   = state_q.cnt;
    assign chan_active = (state_q.st != ST_IDLE);
endmodule

// File: rtl/dma_xfer_channel.sv
module dma_xfer_channel
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_dir,
    input  logic              cfg_m2m,
    input  logic              cfg_circ,
    input  logic              cfg_per_inc,
    input  logic              cfg_mem_inc,
    input  logic [1:0]        cfg_per_size,
    input  logic [1:0]        cfg_mem_size,
    input  logic [ADDR_W-1:0] cfg_per_base,
    input  logic [ADDR_W-1:0] cfg_mem_base,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_ie_half,
    input  logic              cfg_ie_done,
    input  logic              cfg_ie_err,
    input  logic [2:0]        flag_clr,
    input  logic              per_req,
    output logic              per_ack,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err,
    output logic              flag_half,
    output logic              flag_done,
    output logic              flag_err,
    output logic              irq,
    output logic [CNT_W-1:0]  remaining,
    output logic              chan_active
);
    localparam int NUM_SIDES = 2;  // index 0: peripheral, 1: memory

    logic [ADDR_W-1:0] side_cur  [NUM_SIDES];
    logic [ADDR_W-1:0] side_next [NUM_SIDES];
    logic [1:0]        side_size [NUM_SIDES];
    logic              side_inc  [NUM_SIDES];
    logic              side_ok   [NUM_SIDES];
    logic [1:0]        src_size, dst_size;
    logic [DATA_W-1:0] fit_data;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        dma_side_addr #(.ADDR_W(ADDR_W)) u_addr (
            .cur_addr  (side_cur[s]),
            .size      (side_size[s]),
            .inc_en    (side_inc[s]),
            .aligned   (side_ok[s]),
            .next_addr (side_next[s])
        );
    end

    dma_width_fit u_fit (
        .rdata    (bus_rdata),
        .src_size (src_size),
        .dst_size (dst_size),
        .fitted   (fit_data)
    );

    dma_chan_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_en       (cfg_en),
        .cfg_dir      (cfg_dir),
        .cfg_m2m      (cfg_m2m),
        .cfg_circ     (cfg_circ),
        .cfg_per_inc  (cfg_per_inc),
        .cfg_mem_inc  (cfg_mem_inc),
        .cfg_per_size (cfg_per_size),
        .cfg_mem_size (cfg_mem_size),
        .cfg_per_base (cfg_per_base),
        .cfg_mem_base (cfg_mem_base),
        .cfg_count    (cfg_count),
        .flag_clr     (flag_clr),
        .per_req      (per_req),
        .bus_ready    (bus_ready),
        .bus_err      (bus_err),
        .fit_data     (fit_data),
        .per_aligned  (side_ok[0]),
        .mem_aligned  (side_ok[1]),
        .per_next     (side_next[0]),
        .mem_next     (side_next[1]),
        .per_addr     (side_cur[0]),
        .mem_addr     (side_cur[1]),
        .per_size     (side_size[0]),
        .mem_size     (side_size[1]),
        .per_inc      (side_inc[0]),
        .mem_inc      (side_inc[1]),
        .src_size     (src_size),
        .dst_size     (dst_size),
        .per_ack      (per_ack),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .bus_size     (bus_size),
        .bus_wdata    (bus_wdata),
        .flag_half    (flag_half),
        .flag_done    (flag_done),
        .flag_err     (flag_err),
        .remaining    (remaining),
        .chan_active  (chan_active)
    );

    assign irq = (flag_half & cfg_ie_half) | (flag_done & cfg_ie_done) | (flag_err & cfg_ie_err);
endmodule

// File: rtl/dma_xfer_channel_chk.sv
module dma_xfer_channel_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              per_req,
    input logic              per_ack,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              flag_half,
    input logic              flag_done,
    input logic              flag_err,
    input logic              irq,
    input logic [CNT_W-1:0]  remaining,
    input logic              chan_active
);
    p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack && per_req |=> per_ack);

    p_ack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack && !per_req |=> !per_ack);

    p_ack_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_ack) |-> $past(per_req));

    p_half_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && (bus_size == 2'd1) |-> (bus_addr[0] == 1'b0));

    p_word_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && (bus_size == 2'd2) |-> (bus_addr[1:0] == 2'b00));

    p_done_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_done) |-> ($past(remaining) == CNT_W'(1)));

    p_err_halts_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_err) |-> !chan_active);

    p_quiet_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_half && !flag_done && !flag_err |-> !irq);

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        chan_active && $past(chan_active) && (remaining != $past(remaining))
        |-> (remaining == $past(remaining) - CNT_W'(1)) || ($past(remaining) == CNT_W'(1)));
endmodule

bind dma_xfer_channel dma_xfer_channel_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .per_req     (per_req),
    .per_ack     (per_ack),
    .bus_valid   (bus_valid),
    .bus_addr    (bus_addr),
    .bus_size    (bus_size),
    .flag_half   (flag_half),
    .flag_done   (flag_done),
    .flag_err    (flag_err),
    .irq         (irq),
    .remaining   (remaining),
    .chan_active (chan_active)
);

// File: tb/dma_xfer_channel_tb_top.sv
module dma_xfer_channel_tb_top;
    localparam int AW = 32;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic          cfg_en = 0, cfg_dir = 0, cfg_m2m = 0, cfg_circ = 0;
    logic          cfg_per_inc = 0, cfg_mem_inc = 0;
    logic [1:0]    cfg_per_size = 0, cfg_mem_size = 0;
    logic [AW-1:0] cfg_per_base = 0, cfg_mem_base = 0;
    logic [CW-1:0] cfg_count = 0;
    logic          cfg_ie_half = 0, cfg_ie_done = 0, cfg_ie_err = 0;
    logic [2:0]    flag_clr = 0;
    logic          per_req = 0;
    logic          per_ack;
    logic          bus_valid, bus_write;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [31:0]   bus_wdata;
    logic          bus_ready = 0;
    logic [31:0]   bus_rdata = 0;
    logic          bus_err = 0;
    logic          flag_half, flag_done, flag_err, irq;
    logic [CW-1:0] remaining;
    logic          chan_active;

    dma_xfer_channel #(.ADDR_W(AW), .CNT_W(CW)) dut_i (.*);

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
    } wr_item_t;

    wr_item_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    int valid_cycles = 0;
    int cyc = 0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;

    function automatic logic [31:0] mem_model(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] wmask(input logic [1:0] s);
        return (s == 2'd0) ? 32'h0000_00FF : (s == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] wbytes(input logic [1:0] s);
        return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: push the expected writes for items [first, first+n) of the current setup.
    task automatic push_items(input int first, input int n);
        for (int i = first; i < first + n; i++) begin
            logic [31:0] pa, ma, sa;
            wr_item_t it;
            pa = cfg_per_base + (cfg_per_inc ? wbytes(cfg_per_size) * i : 32'd0);
            ma = cfg_mem_base + (cfg_mem_inc ? wbytes(cfg_mem_size) * i : 32'd0);
            sa = cfg_dir ? ma : pa;
            it.addr = cfg_dir ? pa : ma;
            it.data = mem_model(sa) & wmask(cfg_per_size) & wmask(cfg_mem_size);
            exp_q.push_back(it);
        end
    endtask

    // Bus model and monitor, all at the falling edge.
    always @(negedge clk) begin : mon
        wr_item_t e;
        cyc++;
        bus_ready = (cyc % 3) != 1;
        bus_rdata = mem_model(bus_addr);
        bus_err   = bus_valid && bus_ready && (bus_addr == err_addr);
        if (bus_valid) valid_cycles++;
        if (bus_valid && bus_write && bus_ready && !bus_err) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected write at", bus_addr, 32'h0);
            end else begin
                e = exp_q.pop_front();
                chk(bus_addr == e.addr, "R3", "write address", bus_addr, e.addr);
                chk(bus_wdata == e.data, "R4", "write data", bus_wdata, e.data);
            end
        end
    end

    task automatic setup(input bit dir, input bit m2m, input bit circ,
                         input bit pinc, input bit minc, input logic [1:0] ps,
                         input logic [1:0] ms, input logic [31:0] pb,
                         input logic [31:0] mb, input int n);
        @(negedge clk);
        cfg_en = 0;
        flag_clr = 3'b111;
        @(negedge clk);
        flag_clr = 3'b000;
        cfg_dir = dir; cfg_m2m = m2m; cfg_circ = circ;
        cfg_per_inc = pinc; cfg_mem_inc = minc;
        cfg_per_size = ps; cfg_mem_size = ms;
        cfg_per_base = pb; cfg_mem_base = mb;
        cfg_count = CW'(n);
    endtask

    task automatic start();
        @(negedge clk);
        cfg_en = 1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && chan_active; i++) @(negedge clk);
    endtask

    task automatic wait_q_empty();
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic serve_one();
        int w;
        per_req = 1;
        w = 0;
        while (!per_ack && w < 200) begin @(negedge clk); w++; end
        chk(per_ack, "R8", "ack after request", 32'(per_ack), 32'd1);
        repeat (3) @(negedge clk);
        chk(per_ack, "R8", "ack held while request high", 32'(per_ack), 32'd1);
        per_req = 0;
        @(negedge clk);
        chk(!per_ack, "R8", "ack dropped after request fell", 32'(per_ack), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int vc;
        bit ht3, ht2, tc2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13: reset state
        chk(!per_ack && !bus_valid && !flag_half && !flag_done && !flag_err && !irq && !chan_active,
            "R13", "outputs low after reset", 32'(chan_active), 32'd0);
        chk(remaining == 0, "R13", "remaining after reset", 32'(remaining), 32'd0);

        // Memory-to-memory, words, both sides increment (R1 R2 R9 R6 R7)
        setup(0, 1, 0, 1, 1, 2'd2, 2'd2, 32'h1000, 32'h2000, 4);
        cfg_ie_done = 1;
        push_items(0, 4);
        start();
        chk(chan_active, "R1", "active after enable rise", 32'(chan_active), 32'd1);
        chk(remaining == 4, "R1", "count loaded", 32'(remaining), 32'd4);
        wait_idle();
        chk(exp_q.size() == 0, "R9", "all items moved without request", exp_q.size(), 0);
        chk(remaining == 0, "R1", "count reached zero", 32'(remaining), 32'd0);
        chk(flag_done && flag_half, "R6", "half and done flags", {flag_half, flag_done}, 32'd3);
        chk(irq, "R7", "irq with done enabled", 32'(irq), 32'd1);
        repeat (4) @(negedge clk);
        chk(!chan_active, "R1", "no restart while enable stays high", 32'(chan_active), 32'd0);
        // R6: write-one-to-clear
        flag_clr = 3'b111;
        @(negedge clk);
        flag_clr = 3'b000;
        chk(!flag_half && !flag_done && !irq, "R6", "flags cleared", {flag_half, flag_done, irq}, 32'd0);

        // Half flag timing, fixed peripheral halfword source (R6 R3)
        setup(0, 1, 0, 0, 1, 2'd1, 2'd1, 32'h3002, 32'h4000, 5);
        cfg_ie_done = 0;
        cfg_ie_half = 1;
        push_items(0, 5);
        start();
        ht3 = 1; ht2 = 0; tc2 = 1;
        for (int i = 0; i < 3000 && chan_active; i++) begin
            if (remaining == 3) ht3 = flag_half;
            if (remaining == 2) begin ht2 = flag_half; tc2 = flag_done; end
            @(negedge clk);
        end
        chk(!ht3, "R6", "half not set with 3 of 5 left", 32'(ht3), 32'd0);
        chk(ht2 && !tc2, "R6", "half set at floor(5/2) left", {ht2, tc2}, 32'd2);
        chk(exp_q.size() == 0, "R3", "fixed source items done", exp_q.size(), 0);
        flag_clr = 3'b010;
        @(negedge clk);
        flag_clr = 3'b000;
        chk(irq, "R7", "irq stays from enabled half flag", 32'(irq), 32'd1);
        flag_clr = 3'b001;
        @(negedge clk);
        flag_clr = 3'b000;
        chk(!irq, "R7", "irq low after half cleared", 32'(irq), 32'd0);
        cfg_ie_half = 0;

        // Byte source into word destination: zero fill (R4)
        setup(0, 1, 0, 1, 1, 2'd0, 2'd2, 32'h5001, 32'h6000, 3);
        push_items(0, 3);
        start();
        wait_idle();
        chk(exp_q.size() == 0, "R4", "zero-fill items done", exp_q.size(), 0);

        // Word source into byte destination: truncate (R4)
        setup(1, 1, 0, 1, 1, 2'd0, 2'd2, 32'h8003, 32'h7000, 3);
        push_items(0, 3);
        start();
        wait_idle();
        chk(exp_q.size() == 0, "R4", "truncate items done", exp_q.size(), 0);

        // Peripheral handshake (R8)
        setup(1, 0, 0, 0, 1, 2'd2, 2'd2, 32'h9000, 32'hA000, 3);
        push_items(0, 3);
        start();
        vc = valid_cycles;
        repeat (8) @(negedge clk);
        chk(valid_cycles == vc && remaining == 3 && !per_ack, "R8", "no bus access without request",
            valid_cycles - vc, 0);
        for (int k = 0; k < 3; k++) serve_one();
        wait_idle();
        chk(exp_q.size() == 0 && flag_done, "R8", "handshake items done", exp_q.size(), 0);

        // Circular reload in peripheral mode (R10), then abort (R11)
        setup(1, 0, 1, 0, 1, 2'd2, 2'd2, 32'hC000, 32'hB000, 2);
        push_items(0, 2);
        push_items(0, 1);
        start();
        for (int k = 0; k < 3; k++) serve_one();
        wait_q_empty();
        chk(chan_active && flag_done, "R10", "active with done after reload", {chan_active, flag_done}, 32'd3);
        chk(remaining == 1, "R10", "count reloaded then decremented", 32'(remaining), 32'd1);
        cfg_en = 0;
        @(negedge clk);
        chk(!chan_active, "R11", "stopped after enable dropped", 32'(chan_active), 32'd0);
        chk(remaining == 1, "R11", "count held on abort", 32'(remaining), 32'd1);

        // Circular ignored in memory-to-memory mode (R10)
        setup(0, 1, 1, 1, 1, 2'd2, 2'd2, 32'hD000, 32'hE000, 2);
        push_items(0, 2);
        start();
        wait_idle();
        repeat (4) @(negedge clk);
        chk(!chan_active && remaining == 0 && exp_q.size() == 0, "R10", "m2m stops despite circular",
            32'(remaining), 32'd0);

        // Abort mid-transfer, later requests ignored (R11)
        setup(0, 0, 0, 1, 1, 2'd2, 2'd2, 32'h1100, 32'h1200, 5);
        push_items(0, 1);
        start();
        serve_one();
        wait_q_empty();
        chk(remaining == 4, "R11", "one item moved before abort", 32'(remaining), 32'd4);
        cfg_en = 0;
        @(negedge clk);
        vc = valid_cycles;
        per_req = 1;
        repeat (6) begin
            @(negedge clk);
            chk(!per_ack, "R11", "no ack after abort", 32'(per_ack), 32'd0);
        end
        per_req = 0;
        chk(valid_cycles == vc && remaining == 4, "R11", "no bus after abort", 32'(remaining), 32'd4);

        // Misaligned source (R5)
        setup(0, 1, 0, 1, 1, 2'd1, 2'd2, 32'h0F01, 32'h1300, 3);
        cfg_ie_err = 1;
        vc = valid_cycles;
        start();
        wait_idle();
        chk(flag_err && !chan_active, "R5", "error flag and stop", {flag_err, chan_active}, 32'd2);
        chk(remaining == 3 && valid_cycles == vc, "R5", "no access, count kept", 32'(remaining), 32'd3);
        chk(irq, "R7", "irq from enabled error flag", 32'(irq), 32'd1);

        // Bus error on the third read (R12)
        setup(0, 1, 0, 1, 1, 2'd2, 2'd2, 32'hF000, 32'hF800, 4);
        err_addr = 32'hF008;
        push_items(0, 2);
        start();
        wait_idle();
        err_addr = 32'hFFFF_FFFF;
        chk(flag_err && !chan_active, "R12", "bus error stops channel", {flag_err, chan_active}, 32'd2);
        chk(remaining == 2 && exp_q.size() == 0, "R12", "count after bus error", 32'(remaining), 32'd2);

        cfg_en = 0;
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule